// File: doc/BRIEF.md
# Next Program Counter Unit

This block chooses where a 32-bit RISC core fetches next. In each cycle it takes the current program counter, a small control-flow opcode, the two source-register values, a 16-bit immediate and a 26-bit jump index. One clock edge later it presents the next PC, a taken flag, a write strobe and value for the return-address register, and a flag for an unaligned register-jump target.

There are six conditional branch kinds. Two compare two registers for equality or inequality. Four test one register, taken as signed, against zero. Two of the zero tests come in linking forms, which write the return address whether or not the branch is taken. There are also absolute jumps, which keep the region bits of the current PC, and register jumps, each with and without link. Delay slots, flushing and prediction are handled elsewhere.

Top module: `npc_unit`

## Requirements
- R1: While reset (active-low `rstN`) is low, and until the first clock edge after it goes high, `nextPc`, `taken`, `linkWe`, `linkData` and `misaligned` are all zero.
- R2: All outputs are registered and reflect the inputs present at the previous rising edge. Opcode 0 (no control flow) and the unused codes 13 to 15 give `nextPc` = pc+4, `taken` 0 and `linkWe` 0.
- R3: Opcode 1 is taken when `rsVal` equals `rtVal` and opcode 2 is taken when they differ. Comparing register 0 with itself under opcode 1 is therefore always taken. A taken branch goes to pc+4 plus the sign-extended immediate shifted left by two.
- R4: The zero-test branches treat `rsVal` as a signed number. Opcode 3 is taken for a value of zero or less, 4 for greater than zero, 5 and 7 for less than zero, and 6 and 8 for zero or more. They use the same target arithmetic as R3.
- R5: A branch that is not taken gives `nextPc` = pc+4 and `taken` 0.
- R6: Opcodes 9 and 10 are always taken. Their target is pc[31:28] joined with the jump index and two zero bits. The region bits come from the current PC, not from pc+4.
- R7: Opcodes 11 and 12 with `rsVal[1:0]` = 0 are taken to exactly `rsVal`.
- R8: Opcodes 11 and 12 with `rsVal[1:0]` non-zero set `misaligned`, clear `taken` and `linkWe`, and give `nextPc` = pc+4.
- R9: Opcodes 7, 8, 10, and 12 when aligned, set `linkWe` with `linkData` = pc+4. For 7 and 8 this happens taken or not. In every other case `linkData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pc | input | 32 | Address of the current instruction |
| opSel | input | 4 | Control-flow opcode (see R2 to R9) |
| rsVal | input | 32 | First source register value |
| rtVal | input | 32 | Second source register value |
| imm | input | 16 | Branch word offset, signed |
| jIdx | input | 26 | Absolute jump word index |
| nextPc | output | 32 | Selected next fetch address |
| taken | output | 1 | Control left the sequential path |
| linkWe | output | 1 | Write return address to register 31 |
| linkData | output | 32 | Return address value |
| misaligned | output | 1 | Register-jump target not word aligned |

## Verification
Every output is one register stage behind its inputs. A wrong decode, a wrong comparison or a wrong target sum therefore appears at the ports on the very next edge, and only for that instruction. A sign mix-up shows up on backward offsets and on the zero/negative boundary of the register tests. A wrong slice of the region bits shows up only when pc+4 crosses a 256 MB boundary. A dropped link appears as a missing `linkWe` on a linking branch that is not taken.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    OP_SEQ    = 4'd0,
    OP_BEQ    = 4'd1,
    OP_BNE    = 4'd2,
    OP_BLEZ   = 4'd3,
    OP_BGTZ   = 4'd4,
    OP_BLTZ   = 4'd5,
    OP_BGEZ   = 4'd6,
    OP_BLTZL  = 4'd7,
    OP_BGEZL  = 4'd8,
    OP_JMP    = 4'd9,
    OP_JMPL   = 4'd10,
    OP_JREG   = 4'd11,
    OP_JREGL  = 4'd12
  } flowOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selBranch;
    logic selJump;
    logic selReg;
    logic linkEn;
    logic fault;
  } npcStrobe_t;

  // operand conditions from datapath to control
  typedef struct packed {
    logic opEq;
    logic opNeg;
    logic opZero;
    logic regMis;
  } npcFlags_t;

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] opSel,
  input  npcFlags_t  flg,
  output npcStrobe_t stb
);

  flowOp_e opCode;
  assign opCode = flowOp_e'(opSel);

  always_comb begin
    stb = '0;
    case (opCode)
      OP_BEQ:   stb.selBranch = flg.opEq;
      OP_BNE:   stb.selBranch = !flg.opEq;
      OP_BLEZ:  stb.selBranch = flg.opNeg || flg.opZero;
      OP_BGTZ:  stb.selBranch = !flg.opNeg && !flg.opZero;
      OP_BLTZ:  stb.selBranch = flg.opNeg;
      OP_BGEZ:  stb.selBranch = !flg.opNeg;
      OP_BLTZL: begin
        stb.selBranch = flg.opNeg;
        stb.linkEn    = 1'b1;
      end
      OP_BGEZL: begin
        stb.selBranch = !flg.opNeg;
        stb.linkEn    = 1'b1;
      end
      OP_JMP:   stb.selJump = 1'b1;
      OP_JMPL: begin
        stb.selJump = 1'b1;
        stb.linkEn  = 1'b1;
      end
      OP_JREG: begin
        stb.selReg = !flg.regMis;
        stb.fault  = flg.regMis;
      end
      OP_JREGL: begin
        stb.selReg = !flg.regMis;
        stb.fault  = flg.regMis;
        stb.linkEn = !flg.regMis;
      end
      default: stb = '0;
    endcase
  end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.selBranch, stb.selJump, stb.selReg, stb.fault})); // R8
  AST_FAULT_NEEDS_MIS: assert property (@(posedge clk) disable iff (!rstN)
    stb.fault |-> flg.regMis); // R8
  AST_FAULT_NO_LINK: assert property (@(posedge clk) disable iff (!rstN)
    stb.fault |-> !stb.linkEn); // R8

endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] rsVal,
  input  logic [ADDR_W-1:0] rtVal,
  input  logic [IMM_W-1:0]  imm,
  input  logic [IDX_W-1:0]  jIdx,
  input  npcStrobe_t        stb,
  output npcFlags_t         flg,
  output logic [ADDR_W-1:0] nextPc,
  output logic              taken,
  output logic              linkWe,
  output logic [ADDR_W-1:0] linkData,
  output logic              misaligned
);

  localparam int ALIGN_W  = 2;
  localparam int SEXT_W   = ADDR_W - IMM_W - ALIGN_W;
  localparam int REGION_W = ADDR_W - IDX_W - ALIGN_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << ALIGN_W);

  logic [ADDR_W-1:0] fallThru, brOffset, brTarget, jTarget, target;
  logic              takeNow;
  logic              loaded;

  assign flg.opEq   = (rsVal == rtVal);
  assign flg.opNeg  = rsVal[ADDR_W-1];
  assign flg.opZero = (rsVal == '0);
  assign flg.regMis = |rsVal[ALIGN_W-1:0];

  assign fallThru = pc + STEP;
  assign brOffset = {{SEXT_W{imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
  assign brTarget = fallThru + brOffset;
  assign jTarget  = {pc[ADDR_W-1 -: REGION_W], jIdx, {ALIGN_W{1'b0}}};

  always_comb begin
    if (stb.selBranch)    target = brTarget;
    else if (stb.selJump) target = jTarget;
    else if (stb.selReg)  target = rsVal;
    else                  target = fallThru;
  end

  assign takeNow = stb.selBranch || stb.selJump || stb.selReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc     <= '0;
      taken      <= 1'b0;
      linkWe     <= 1'b0;
      linkData   <= '0;
      misaligned <= 1'b0;
      loaded     <= 1'b0;
    end else begin
      nextPc     <= target;
      taken      <= takeNow;
      linkWe     <= stb.linkEn;
      linkData   <= stb.linkEn ? fallThru : '0;
      misaligned <= stb.fault;
      loaded     <= 1'b1;
    end
  end

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    loaded && !taken |-> nextPc == $past(pc) + STEP); // R5
  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    loaded && linkWe |-> linkData == $past(pc) + STEP); // R9
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rstN)
    loaded && $past(stb.selJump) |-> nextPc[ADDR_W-1 -: REGION_W] == $past(pc[ADDR_W-1 -: REGION_W])); // R6
  AST_REG_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    loaded && $past(stb.selReg) |-> nextPc == $past(rsVal)); // R7
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> !taken && !linkWe); // R8

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] pc,
  input  logic [3:0]        opSel,
  input  logic [ADDR_W-1:0] rsVal,
  input  logic [ADDR_W-1:0] rtVal,
  input  logic [IMM_W-1:0]  imm,
  input  logic [IDX_W-1:0]  jIdx,
  output logic [ADDR_W-1:0] nextPc,
  output logic              taken,
  output logic              linkWe,
  output logic [ADDR_W-1:0] linkData,
  output logic              misaligned
);

  npcStrobe_t stb;
  npcFlags_t  flg;

  npc_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .opSel (opSel),
    .flg   (flg),
    .stb   (stb)
  );

  npc_datapath #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .IDX_W  (IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pc         (pc),
    .rsVal      (rsVal),
    .rtVal      (rtVal),
    .imm        (imm),
    .jIdx       (jIdx),
    .stb        (stb),
    .flg        (flg),
    .nextPc     (nextPc),
    .taken      (taken),
    .linkWe     (linkWe),
    .linkData   (linkData),
    .misaligned (misaligned)
  );

endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pc = '0, rsVal = '0, rtVal = '0;
  logic [3:0]  opSel = '0;
  logic [15:0] imm = '0;
  logic [25:0] jIdx = '0;
  logic [31:0] nextPc, linkData;
  logic        taken, linkWe, misaligned;
  int          nRun = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit dut (
    .clk(clk), .rstN(rstN), .pc(pc), .opSel(opSel), .rsVal(rsVal),
    .rtVal(rtVal), .imm(imm), .jIdx(jIdx), .nextPc(nextPc), .taken(taken),
    .linkWe(linkWe), .linkData(linkData), .misaligned(misaligned)
  );

  function automatic string reqOf(input int op, input logic [31:0] rs);
    if (op == 1 || op == 2) return "R3";
    if (op >= 3 && op <= 6) return "R4";
    if (op == 7 || op == 8) return "R9";
    if (op == 9 || op == 10) return "R6";
    if (op == 11 || op == 12) return (rs[1:0] != 0) ? "R8" : "R7";
    return "R2";
  endfunction

  task automatic checkOut(input string tag, input logic [31:0] eNpc, input logic eTk,
                          input logic eLw, input logic [31:0] eLd, input logic eMis);
    nRun++;
    if (nextPc !== eNpc || taken !== eTk || linkWe !== eLw || linkData !== eLd || misaligned !== eMis) begin
      nFail++;
      $display("FAIL %s: got npc=%h tk=%b lw=%b ld=%h mis=%b, exp npc=%h tk=%b lw=%b ld=%h mis=%b",
               tag, nextPc, taken, linkWe, linkData, misaligned, eNpc, eTk, eLw, eLd, eMis);
    end
  endtask

  // behavioural reference
  task automatic step(input int op, input logic [31:0] p, input logic [31:0] rs,
                      input logic [31:0] rt, input logic [15:0] im, input logic [25:0] ix);
    longint sRs, tgt;
    logic [31:0] eNpc, eLd;
    logic eTk, eLw, eMis, cond;
    sRs = longint'($signed(rs));
    tgt = longint'(p) + 4 + longint'($signed(im)) * 4;
    cond = 1'b0; eTk = 0; eLw = 0; eMis = 0;
    eNpc = p + 32'd4;
    case (op)
      1: cond = (rs == rt);
      2: cond = (rs != rt);
      3: cond = (sRs <= 0);
      4: cond = (sRs > 0);
      5, 7: cond = (sRs < 0);
      6, 8: cond = (sRs >= 0);
      default: cond = 1'b0;
    endcase
    if (op >= 1 && op <= 8 && cond) begin eTk = 1; eNpc = 32'(tgt); end
    if (op == 7 || op == 8) eLw = 1;
    if (op == 9 || op == 10) begin eTk = 1; eNpc = (p & 32'hF000_0000) | (32'(ix) * 4); end
    if (op == 10) eLw = 1;
    if (op == 11 || op == 12) begin
      if (rs[1:0] != 0) eMis = 1;
      else begin eTk = 1; eNpc = rs; if (op == 12) eLw = 1; end
    end
    eLd = eLw ? p + 32'd4 : 32'd0;
    @(negedge clk);
    opSel = 4'(op); pc = p; rsVal = rs; rtVal = rt; imm = im; jIdx = ix;
    @(posedge clk);
    @(negedge clk);
    checkOut(reqOf(op, rs), eNpc, eTk, eLw, eLd, eMis);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkOut("R1", 32'd0, 1'b0, 1'b0, 32'd0, 1'b0);
    rstN = 1'b1;
    #1;
    checkOut("R1", 32'd0, 1'b0, 1'b0, 32'd0, 1'b0);

    step(0,  32'h0040_0010, 0, 0, 16'h0005, 0);                       // R2
    step(14, 32'h0040_0020, 5, 5, 16'h0003, 26'h12);                  // R2 unused code
    step(1,  32'h0040_0100, 0, 0, 16'hFFFC, 0);                       // R3 unconditional, -16
    step(2,  32'h0040_0100, 3, 4, 16'hFFFA, 0);                       // R3 bne -24
    step(2,  32'h0040_0100, 4, 4, 16'hFFFA, 0);                       // R5 bne not taken
    step(1,  32'h0040_0200, 9, 9, 16'h0007, 0);                       // R3 forward +28
    step(1,  32'h0040_0200, 9, 8, 16'h0007, 0);                       // R5
    step(3,  32'h0040_0300, 0, 0, 16'h0010, 0);                       // R4 blez zero
    step(3,  32'h0040_0300, 1, 0, 16'h0010, 0);                       // R4 blez positive
    step(4,  32'h0040_0300, 0, 0, 16'h0010, 0);                       // R4 bgtz zero
    step(4,  32'h0040_0300, 32'h7FFF_FFFF, 0, 16'h8000, 0);           // R4 most negative offset
    step(5,  32'h0040_0300, 32'h8000_0000, 0, 16'h7FFF, 0);           // R4 bltz
    step(6,  32'h0040_0300, 32'hFFFF_FFFF, 0, 16'h0001, 0);           // R4 bgez negative
    step(7,  32'h0040_0400, 32'h0000_0001, 0, 16'hFFF0, 0);           // R9 link not taken
    step(8,  32'h0040_0400, 32'h0000_0000, 0, 16'hFFF0, 0);           // R9 link taken
    step(9,  32'h0FFF_FFFC, 0, 0, 0, 26'h3FF_FFFF);                   // R6 region boundary
    step(10, 32'h1000_0000, 0, 0, 0, 26'h000_5014);                   // R6 link jump
    step(11, 32'h0040_0500, 32'h0040_1000, 0, 0, 0);                  // R7
    step(12, 32'h0040_0500, 32'h0040_2000, 0, 0, 0);                  // R7 linked
    step(11, 32'h0040_0500, 32'h0040_1002, 0, 0, 0);                  // R8
    step(12, 32'h0040_0500, 32'h0040_1001, 0, 0, 0);                  // R8 no link

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r1, r2;
      int op;
      op = $urandom_range(0, 15);
      r1 = $urandom;
      r2 = ($urandom_range(0, 3) == 0) ? r1 : $urandom;
      if ($urandom_range(0, 7) == 0) r1 = 0;
      if (op >= 11 && op <= 12 && $urandom_range(0, 1) == 0) r1[1:0] = 2'b00;
      step(op, $urandom & 32'hFFFF_FFFC, r1, r2, 16'($urandom), 26'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule